// File: doc/BRIEF.md
# External Interrupt Request Generator with Keyboard-OR Inputs

This block produces the interrupt request for a small 8-bit controller core. It watches an active-low external interrupt pin and the four low port pins. Each port pin can be enabled on its own to join the interrupt pin in a wired-OR of active-low sources. All five raw inputs pass through a two-flop synchronizer. The enabled sources are then merged into one combined low signal, and edge detection runs on that merged signal.

A falling edge of the merged signal sets a pending latch. A one-cycle acknowledge strobe from the core clears that latch. One sensitivity option covers the pin and every enabled port pin alike, and it selects one of two modes:
- **Edge mode:** the request is the pending latch alone.
- **Level mode:** the request is the pending latch ORed with the current synchronized low level. The request therefore returns after an acknowledge while any enabled source is still held low.

A mask input blocks only the request output. Latching continues while masked, so an edge that arrives under the mask is still pending when the mask is removed.

Top module: `extint_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `irqReq` is 0 and the pending latch is clear. All synchronizer stages reset to the inactive (high) level.
- R2: Each raw input passes through two synchronizer flops. A falling edge driven between clock edges sets the pending latch on the third following rising edge. With `levelMode`=0 and `irqMask`=0, `irqReq` rises after that edge and not earlier.
- R3: With `levelMode`=0, an input held low gives exactly one request. After `ack`, `irqReq` stays 0 for as long as the input remains low.
- R4: With `levelMode`=1, `irqReq` is 1 from the second rising edge after an enabled source goes low. It stays 1 after `ack` while the source is held low. It falls to 0 two edges after release if nothing is pending.
- R5: Port pin i (bit i of `portPinN`) takes part in the OR only when `portEnable[i]`=1. A disabled port pin going low never sets pending or raises `irqReq`.
- R6: The sensitivity selected by `levelMode` applies to enabled port pins exactly as it does to `irqPinN`.
- R7: Edges are detected on the merged signal. A second source going low while another enabled source is already low creates no new pending event. Several sources falling in the same cycle create one event.
- R8: While `irqMask`=1, `irqReq` is 0, but edges still set the pending latch. Clearing the mask exposes the pending request in the same cycle.
- R9: A high `ack` at a rising edge clears the pending latch. If a new edge is detected at that same rising edge, the set wins and the latch stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 1 | Raw active-low external interrupt pin |
| portPinN | input | 4 | Raw low port pins, active low when enabled |
| levelMode | input | 1 | 0: falling edge only; 1: falling edge plus low level |
| portEnable | input | 4 | Per-pin enable of port pins into the OR |
| irqMask | input | 1 | 1 blocks the request output |
| ack | input | 1 | One-cycle acknowledge that clears pending |
| irqReq | output | 1 | Interrupt request to the core |

## Verification
The acknowledge that clears the pending latch and a freshly detected falling edge that sets it can land on the same rising edge. The bench provokes this by pulsing `ack` so that it is sampled on exactly the edge where a new pin fall reaches the end of the synchronizer. It then requires `irqReq` to be high afterwards. A second collision is a port pin and the interrupt pin falling together. That case must yield one pending event, which a single acknowledge retires. A cycle model in the bench also replays long random mixes of pins, acknowledges, mask and mode changes, so both collisions recur at random phases.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Strobes issued by control toward the pending latch in the datapath
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } extintStrobe_t;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '1;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic [NUM_PORT-1:0] portEnable,
  input  logic                levelMode,
  input  logic                irqMask,
  input  extintStrobe_t       strobe,
  output logic                combLow,
  output logic                prevLow,
  output logic                irqReq
);

  localparam int NUM_SRC = NUM_PORT + 1;

  logic [NUM_SRC-1:0]  rawN;
  logic [NUM_SRC-1:0]  syncN;
  logic [NUM_PORT-1:0] portLow;
  logic                pendQ;

  assign rawN = {portPinN, irqPinN};

  extint_sync #(
    .WIDTH (NUM_SRC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawN),
    .syncOut(syncN)
  );

  // Wired-OR of active-low sources: pin always, port pins when enabled
  generate
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      assign portLow[p] = portEnable[p] & ~syncN[p+1];
    end
  endgenerate

  assign combLow = ~syncN[0] | (|portLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLow <= 1'b0;
    end else begin
      prevLow <= combLow;
    end
  end

  // Pending latch: a set outranks a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (strobe.setPend) begin
      pendQ <= 1'b1;
    end else if (strobe.clrPend) begin
      pendQ <= 1'b0;
    end
  end

  assign irqReq = ~irqMask & (pendQ | (levelMode & combLow));

  assert_pend_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(strobe.setPend));

  assert_pend_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> $past(strobe.clrPend && !strobe.setPend));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |=> pendQ);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          combLow,
  input  logic          prevLow,
  input  logic          ack,
  output extintStrobe_t strobe
);

  logic fallSeen;

  // Edge on the merged signal only; a second low source adds nothing
  assign fallSeen = combLow & ~prevLow;

  always_comb begin
    strobe         = '0;
    strobe.setPend = fallSeen;
    strobe.clrPend = ack;
  end

  assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |=> !strobe.setPend);

endmodule

// File: rtl/extint_top.sv
module extint_top
  import extint_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic                levelMode,
  input  logic [NUM_PORT-1:0] portEnable,
  input  logic                irqMask,
  input  logic                ack,
  output logic                irqReq
);

  extintStrobe_t strobe;
  logic          combLow;
  logic          prevLow;

  extint_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .combLow(combLow),
    .prevLow(prevLow),
    .ack    (ack),
    .strobe (strobe)
  );

  extint_datapath #(
    .NUM_PORT   (NUM_PORT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqPinN   (irqPinN),
    .portPinN  (portPinN),
    .portEnable(portEnable),
    .levelMode (levelMode),
    .irqMask   (irqMask),
    .strobe    (strobe),
    .combLow   (combLow),
    .prevLow   (prevLow),
    .irqReq    (irqReq)
  );

  assert_mask_gates_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irqReq);

  assert_level_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && combLow && !irqMask) |-> irqReq);

  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!irqReq);
    end
  end

endmodule

// File: tb/tb_extint_top.sv
`timescale 1ns/1ps
module tb_extint_top;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irqPinN = 1'b1;
  logic [NP-1:0] portPinN = '1;
  logic          levelMode = 1'b0;
  logic [NP-1:0] portEnable = 4'b0101;
  logic          irqMask = 1'b0;
  logic          ack = 1'b0;
  logic          irqReq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  extint_top #(.NUM_PORT(NP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .levelMode(levelMode), .portEnable(portEnable), .irqMask(irqMask),
    .ack(ack), .irqReq(irqReq)
  );

  // Cycle model built from R1..R9
  logic [NP:0] ms1, ms2;
  logic        mPrev, mPend;

  function automatic logic mergedLow(logic [NP:0] s, logic [NP-1:0] en);
    return ~s[0] | (|(~s[NP:1] & en));
  endfunction

  function automatic logic expectReq(logic pend, logic [NP:0] s);
    return ~irqMask & (pend | (levelMode & mergedLow(s, portEnable)));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ms1 <= '1; ms2 <= '1; mPrev <= 1'b0; mPend <= 1'b0;
    end else begin
      ms1   <= {portPinN, irqPinN};
      ms2   <= ms1;
      mPrev <= mergedLow(ms2, portEnable);
      if (mergedLow(ms2, portEnable) && !mPrev) mPend <= 1'b1;
      else if (ack)                            mPend <= 1'b0;
    end
  end

  // Model comparison 1 ns after every rising edge, inputs are stable then
  always @(posedge clk) begin
    #1;
    checks++;
    if (irqReq !== expectReq(mPend, ms2)) begin
      errors++;
      $display("FAIL model(R2-R9 cycle model) t=%0t actual=%b expected=%b",
               $time, irqReq, expectReq(mPend, ms2));
    end
  end

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (irqReq !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, irqReq, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAck();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk("R1 during reset", 1'b0);
    rstN = 1'b1;
    step(1);
    chk("R1 after reset", 1'b0);
    step(3);

    // R2 / R3: edge mode latency and single request while held low
    irqPinN = 1'b0;
    step(1); chk("R2 one edge", 1'b0);
    step(1); chk("R2 two edges", 1'b0);
    step(1); chk("R2 three edges", 1'b1);
    step(8); chk("R3 held pending", 1'b1);
    pulseAck(); chk("R3 cleared by ack", 1'b0);
    step(8); chk("R3 no repeat while held", 1'b0);
    irqPinN = 1'b1; step(4);

    // R4: level mode
    levelMode = 1'b1;
    irqPinN = 1'b0;
    step(1); chk("R4 level one edge", 1'b0);
    step(1); chk("R4 level two edges", 1'b1);
    step(4);
    pulseAck(); chk("R4 reassert after ack", 1'b1);
    irqPinN = 1'b1;
    step(2); chk("R4 drop after release", 1'b0);
    step(2);
    levelMode = 1'b0;

    // R5: enabled port pin 2 and disabled port pin 1
    portPinN[2] = 1'b0;
    step(3); chk("R5 enabled port edge", 1'b1);
    pulseAck(); portPinN[2] = 1'b1; step(4);
    chk("R5 cleared", 1'b0);
    portPinN[1] = 1'b0;
    step(6); chk("R5 disabled port ignored", 1'b0);
    portPinN[1] = 1'b1; step(4);

    // R6: level sensitivity shared by port pin 0
    levelMode = 1'b1;
    portPinN[0] = 1'b0;
    step(2); chk("R6 port level", 1'b1);
    step(3);
    pulseAck(); chk("R6 port reassert", 1'b1);
    portPinN[0] = 1'b1;
    step(2); chk("R6 port release", 1'b0);
    levelMode = 1'b0; step(2);

    // R7: second source while first low, then simultaneous fall
    irqPinN = 1'b0; step(5);
    pulseAck(); chk("R7 first acked", 1'b0);
    portPinN[0] = 1'b0;
    step(6); chk("R7 no new edge", 1'b0);
    irqPinN = 1'b1; portPinN[0] = 1'b1; step(4);
    irqPinN = 1'b0; portPinN[2] = 1'b0;
    step(3); chk("R7 simultaneous one event", 1'b1);
    pulseAck(); chk("R7 single ack retires", 1'b0);
    step(4); chk("R7 still retired", 1'b0);
    irqPinN = 1'b1; portPinN[2] = 1'b1; step(4);

    // R8: mask gates output, latch keeps edge
    irqMask = 1'b1;
    irqPinN = 1'b0; step(5);
    chk("R8 masked", 1'b0);
    irqPinN = 1'b1; step(3);
    irqMask = 1'b0; #0.5;
    chk("R8 pending revealed", 1'b1);
    step(1);
    pulseAck(); step(2);

    // R9: ack on the same edge as a new fall
    irqPinN = 1'b0;
    step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R9 set beats clear", 1'b1);
    pulseAck(); chk("R9 plain ack clears", 1'b0);
    irqPinN = 1'b1; step(4);

    // Random mix checked by the model
    for (int i = 0; i < 4000; i++) begin
      irqPinN  = ($urandom_range(0, 3) != 0);
      portPinN = NP'($urandom);
      ack      = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 40) == 0) irqMask = ~irqMask;
      if ($urandom_range(0, 60) == 0) levelMode = ~levelMode;
      if ($urandom_range(0, 80) == 0) portEnable = NP'($urandom);
      step($urandom_range(1, 3));
    end
    ack = 1'b0;
    step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule